// File: doc/BRIEF.md
# SPI Master Interrupt Aggregator and Soft-Reset Unit

This block sits on the register bus of an SPI master. It collects single-cycle event pulses from the SPI core and keeps each one in a sticky pending bit. Each pending bit is masked by its own enable bit. The masked bits are combined into one level-sensitive interrupt line, and that line is further gated by a single global enable bit.

Software clears pending bits by writing back the value it read from the pending register: every bit written as 1 is cleared. A separate reset register drives a reset pulse to the peripheral. The pulse starts only when that register is written with one key value, and it lasts a fixed, parameterised number of clocks. While the pulse is high it also holds the pending register at zero.

Register reads are combinational from the address. Writes take effect at the clock edge on which `bus_wen` is high.

Top module: `spi_irq_rst_ctl`

## Requirements
- R1: After `rst_n` is released, every register reads 0, `irq_o` is 0 and `periph_rst_o` is 0.
- R2: Register map (byte offsets on `bus_addr`):
  - 0x1c is the global enable. Only bit 31 is stored; every other bit reads 0.
  - 0x20 is the pending register.
  - 0x28 is the per-source enable register, bits [6:0].
  - 0x40 is the reset register, which reads 0.
  - Any other offset reads 0, and writes to it change nothing.
- R3: An event pulse on `ev_pulse[i]` sets pending bit i at the next clock edge, whatever the value of enable bit i.
- R4: A write to 0x20 clears each pending bit written as 1 and leaves the bits written as 0 unchanged. If an event for a bit arrives in the same cycle as a clear of that bit, the bit ends up set.
- R5: `irq_o` is high exactly when the global enable is 1 and at least one bit is both pending and enabled. It follows register state within the same cycle.
- R6: A write of exactly 0x0000000a to 0x40 raises `periph_rst_o` at the next clock edge and holds it high for `RST_CYCLES` clocks. A write of any other value to 0x40 leaves `periph_rst_o` low.
- R7: While `periph_rst_o` is high, the pending register is cleared and incoming events are dropped. The enable register and the global enable keep their values.
- R8: Source bit positions:

| Bit | Source |
|-----|--------|
| 0 | mode fault |
| 1 | slave mode fault |
| 2 | TX FIFO empty |
| 3 | TX underrun |
| 4 | RX full |
| 5 | RX overrun |
| 6 | TX half empty |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ev_pulse | input | N_SRC | Single-cycle event pulses from the SPI core |
| irq_o | output | 1 | Level interrupt to the host |
| periph_rst_o | output | 1 | Reset pulse to the SPI peripheral |

## Verification
A wrong pending bit shows up on `bus_rdata` at offset 0x20 one clock after the event or clear that caused it. It shows up on `irq_o` in that same cycle whenever the matching enable bit is set. This is why the sweep crosses every source with every enable pattern.

A wrong reset counter shows up either as a pulse on `periph_rst_o` after a bad key, or as a pulse whose width differs from `RST_CYCLES`. The bench measures both.

A broken priority between event and clear appears as a zero in the pending read back right after a same-cycle collision.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int GIE_BIT = 31;

  localparam logic [ADDR_W-1:0] OFS_GIE = 8'h1c;
  localparam logic [ADDR_W-1:0] OFS_PND = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_ENA = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_RST = 8'h40;

  localparam logic [DATA_W-1:0] RST_KEY = 32'h0000_000a;

  // Combined interrupt level: global gate over any masked pending bit.
  function automatic logic irq_level(input logic gie,
                                     input logic [DATA_W-1:0] pnd,
                                     input logic [DATA_W-1:0] ena);
    return gie & (|(pnd & ena));
  endfunction

  // Next pending state: clear-by-one, then events win, reset pulse wins over all.
  function automatic logic [DATA_W-1:0] pend_next(input logic [DATA_W-1:0] cur,
                                                  input logic [DATA_W-1:0] ev,
                                                  input logic [DATA_W-1:0] clr,
                                                  input logic srst);
    if (srst) return '0;
    return (cur & ~clr) | ev;
  endfunction

  function automatic logic key_hit(input logic [DATA_W-1:0] d);
    return d == RST_KEY;
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import spi_irq_pkg::*;
#(
  parameter int N_SRC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] ev_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] clr_mask_i,
  input  logic             srst_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] clr_eff;
  logic [DATA_W-1:0] nxt_w;

  assign clr_eff = clr_we_i ? clr_mask_i : '0;
  assign nxt_w   = pend_next(DATA_W'(pend_q), DATA_W'(ev_i), DATA_W'(clr_eff), srst_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= nxt_w[N_SRC-1:0];
  end

  assign pend_o = pend_q;

  // R3: an event sets its bit at the next edge unless the reset pulse is active
  a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0 && !srst_i) |=> ((pend_q & $past(ev_i)) == $past(ev_i)));

  // R4: bits cleared without a coinciding event read 0 afterwards
  a_r4_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && !srst_i) |=> ((pend_q & $past(clr_mask_i & ~ev_i)) == '0));

  // R4: bits written as 0 are untouched by a clear
  a_r4_keep_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && !srst_i && ev_i == '0) |=>
      ((pend_q & ~$past(clr_mask_i)) == ($past(pend_q) & ~$past(clr_mask_i))));

  // R7: reset pulse empties the pending register
  a_r7_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> (pend_q == '0));
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import spi_irq_pkg::*;
#(
  parameter int N_SRC = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ena_we_i,
  input  logic              gie_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_SRC-1:0]  pend_i,
  output logic [N_SRC-1:0]  ena_o,
  output logic              gie_o,
  output logic              irq_o
);
  logic [N_SRC-1:0] ena_q;
  logic             gie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
      gie_q <= 1'b0;
    end else begin
      if (ena_we_i) ena_q <= wdata_i[N_SRC-1:0];
      if (gie_we_i) gie_q <= wdata_i[GIE_BIT];
    end
  end

  assign ena_o = ena_q;
  assign gie_o = gie_q;
  assign irq_o = irq_level(gie_q, DATA_W'(pend_i), DATA_W'(ena_q));

  // R5: interrupt only through the global gate
  a_r5_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> gie_o);

  // R5: interrupt only with a pending source present
  a_r5_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_i != '0));

  // R2: global enable follows bit 31 of its write
  a_r2_gie_write: assert property (@(posedge clk) disable iff (!rst_n)
    gie_we_i |=> (gie_o == $past(wdata_i[GIE_BIT])));
endmodule

// File: rtl/soft_rst_gen.sv
module soft_rst_gen
  import spi_irq_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              pulse_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             fire;

  assign fire = we_i & key_hit(wdata_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (fire)       cnt_q <= CNT_LOAD;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);

  // R6: a good key starts the pulse at the next edge
  a_r6_key_fires: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pulse_o);

  // R6: a bad key from idle never starts a pulse
  a_r6_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !key_hit(wdata_i) && !pulse_o) |=> !pulse_o);

  generate
    if (RST_CYCLES > 1) begin : g_long
      // R6: pulse is wider than one clock
      a_r6_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |=> pulse_o);
    end
  endgenerate
endmodule

// File: rtl/spi_irq_rst_ctl.sv
module spi_irq_rst_ctl
  import spi_irq_pkg::*;
#(
  parameter int N_SRC      = 7,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  ev_pulse,
  output logic              irq_o,
  output logic              periph_rst_o
);
  logic             wr_gie, wr_pnd, wr_ena, wr_rst;
  logic [N_SRC-1:0] pend_w, ena_w;
  logic             gie_w;
  logic             srst_w;

  assign wr_gie = bus_wen && (bus_addr == OFS_GIE);
  assign wr_pnd = bus_wen && (bus_addr == OFS_PND);
  assign wr_ena = bus_wen && (bus_addr == OFS_ENA);
  assign wr_rst = bus_wen && (bus_addr == OFS_RST);

  irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_i       (ev_pulse),
    .clr_we_i   (wr_pnd),
    .clr_mask_i (bus_wdata[N_SRC-1:0]),
    .srst_i     (srst_w),
    .pend_o     (pend_w)
  );

  irq_mask_unit #(.N_SRC(N_SRC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .ena_we_i (wr_ena),
    .gie_we_i (wr_gie),
    .wdata_i  (bus_wdata),
    .pend_i   (pend_w),
    .ena_o    (ena_w),
    .gie_o    (gie_w),
    .irq_o    (irq_o)
  );

  soft_rst_gen #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (wr_rst),
    .wdata_i (bus_wdata),
    .pulse_o (srst_w)
  );

  assign periph_rst_o = srst_w;

  always_comb begin
    case (bus_addr)
      OFS_GIE: bus_rdata = {gie_w, {(DATA_W-1){1'b0}}};
      OFS_PND: bus_rdata = DATA_W'(pend_w);
      OFS_ENA: bus_rdata = DATA_W'(ena_w);
      default: bus_rdata = '0;
    endcase
  end

  // R7: enables survive the reset pulse
  a_r7_ena_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_w && !wr_ena) |=> (ena_w == $past(ena_w)));

  // R1: nothing is asserted out of reset
  a_r1_quiet_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!irq_o && !periph_rst_o));
endmodule

// File: tb/sim_spi_irq_rst_ctl.sv
module sim_spi_irq_rst_ctl;
  localparam int NS = 7;
  localparam int PW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NS-1:0] ev_pulse = '0;
  logic        irq_o, periph_rst_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_irq_rst_ctl #(.N_SRC(NS), .RST_CYCLES(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pulse(ev_pulse),
    .irq_o(irq_o), .periph_rst_o(periph_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [NS-1:0] m);
    @(negedge clk);
    ev_pulse = m;
    @(negedge clk);
    ev_pulse = '0;
  endtask

  logic [31:0] r;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h1c, r); chk("R1 gie", r, 0);
    rd(8'h20, r); chk("R1 pend", r, 0);
    rd(8'h28, r); chk("R1 ena", r, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 rst", periph_rst_o, 0);

    // R2 global enable stores only bit 31
    wr(8'h1c, 32'h7fff_ffff); rd(8'h1c, r); chk("R2 gie low bits", r, 0);
    wr(8'h1c, 32'hffff_ffff); rd(8'h1c, r); chk("R2 gie bit31", r, 32'h8000_0000);
    wr(8'h28, 32'hffff_ffff); rd(8'h28, r); chk("R2 ena width", r, 32'h7f);
    wr(8'h24, 32'hffff_ffff); rd(8'h24, r); chk("R2 unmapped read", r, 0);
    rd(8'h28, r); chk("R2 unmapped write no effect", r, 32'h7f);
    rd(8'h40, r); chk("R2 reset reg reads 0", r, 0);

    // R3/R5/R8 sweep: every source against every enable pattern, gate on
    for (int s = 0; s < NS; s++) begin
      for (int e = 0; e < (1 << NS); e++) begin
        wr(8'h28, 32'(e));
        pulse(NS'(1 << s));
        rd(8'h20, r); chk("R3 R8 pending bit set", r, 32'(1 << s));
        chk("R5 irq vs enable", irq_o, 32'((e >> s) & 1));
        wr(8'h20, 32'h7f);
        chk("R4 cleared irq", irq_o, 0);
      end
    end

    // R5 gate off hides pending sources
    wr(8'h28, 32'h7f);
    wr(8'h1c, 32'h0);
    pulse(NS'(7'h7f));
    chk("R5 gie off", irq_o, 0);
    rd(8'h20, r); chk("R3 pending with gate off", r, 32'h7f);
    wr(8'h1c, 32'h8000_0000);
    chk("R5 gie on", irq_o, 1);

    // R4 partial clear
    wr(8'h20, 32'h15);
    rd(8'h20, r); chk("R4 partial clear", r, 32'h6a);
    // R4 event wins over same-cycle clear
    wr(8'h20, 32'h7f);
    @(negedge clk);
    bus_addr = 8'h20; bus_wdata = 32'h05; bus_wen = 1'b1; ev_pulse = NS'(7'h04);
    @(negedge clk);
    bus_wen = 1'b0; ev_pulse = '0;
    rd(8'h20, r); chk("R4 event beats clear", r, 32'h04);
    wr(8'h20, 32'h7f);

    // R6 bad keys
    for (int v = 0; v < 40; v++) begin
      if (v != 10) begin
        wr(8'h40, 32'(v));
        chk("R6 bad key", periph_rst_o, 0);
        @(negedge clk);
        chk("R6 bad key later", periph_rst_o, 0);
      end
    end
    wr(8'h40, 32'h8000_000a); chk("R6 bad key high bit", periph_rst_o, 0);
    wr(8'h40, 32'h0000_010a); chk("R6 bad key mid bit", periph_rst_o, 0);
    wr(8'h44, 32'h0000_000a); chk("R6 key at wrong offset", periph_rst_o, 0);

    // R6/R7 good key: width, clearing, enables kept
    pulse(NS'(7'h33));
    wr(8'h40, 32'h0000_000a);
    begin
      int w = 0;
      ev_pulse = NS'(7'h7f);
      while (periph_rst_o === 1'b1 && w < 100) begin
        w++;
        @(negedge clk);
        ev_pulse = '0;
      end
      chk("R6 pulse width", 32'(w), 32'(PW));
    end
    rd(8'h20, r); chk("R7 pending cleared", r, 0);
    rd(8'h28, r); chk("R7 ena kept", r, 32'h7f);
    rd(8'h1c, r); chk("R7 gie kept", r, 32'h8000_0000);
    chk("R7 irq low", irq_o, 0);
    pulse(NS'(7'h01));
    chk("R3 after reset pulse", irq_o, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule